// File: doc/BRIEF.md
# Dirty Band Update Coalescer

This block walks a frame buffer from top to bottom in bands of four scan lines, one band per memory page. For each band it asks an external dirty-bit store, through a request/acknowledge lookup, whether the page behind that band was written since the last pass. Neighbouring dirty bands are merged into a single update rectangle that spans the full active width. A redraw engine downstream consumes these rectangles, so one rectangle is issued per run of dirty bands rather than one per band.

During the pass the block keeps the lowest and highest dirty band index. Once the last band has been handled, it issues a single clear request for that range, provided at least one band was dirty, and then pulses done. When the deep mode is selected, a band also counts as dirty if any of its four direct-colour pages or any of its four control pages is dirty. An invalidate command makes the next pass treat every band as dirty, so the whole screen is redrawn.

Top module: `dirty_band_coalescer`

## Requirements
- R1: After reset, lk_req, rect_valid, clr_valid, done and busy are all 0.
- R2: A dirty band opens a run when no run is open, and later dirty bands extend that run. The first clean band closes the run and emits one rectangle with rect_y equal to the first line of the run, rect_h equal to the first line of the clean band minus rect_y, and rect_w equal to the active_width captured at scan start. The x origin is always 0.
- R3: A run that is still open after the last band is emitted as a rectangle whose height reaches the line just past that band: 4 × band count − rect_y.
- R4: Band k covers lines 4k to 4k+3. The lookups ask for bands 0, 1, … up to ceil(active_lines/4)−1, in ascending order through lk_band. Only one request is outstanding at a time, and it is held until lk_ack.
- R5: With deep_mode=0, only lk_base_dirty marks a band dirty. With deep_mode=1, a band is also dirty if any bit of lk_direct_dirty or lk_ctrl_dirty is set.
- R6: After the last band, a one-cycle clr_valid is issued with clr_lo and clr_hi equal to the lowest and highest dirty band index of the pass. No clear is issued when no band was dirty.
- R7: An invalidate pulse makes the following pass treat every band as dirty, producing one full-height rectangle and a clear of 0 to the last band. It applies to one pass only. If the pulse arrives during a pass, it is held for the next pass.
- R8: While rect_ready is low, rect_valid stays high with rect_y, rect_h and rect_w unchanged, and no lookup is requested.
- R9: done is a one-cycle pulse. It comes in the cycle after clr_valid, or, when nothing was dirty, in the cycle after the last band's acknowledge.
- R10: scan_start is ignored while busy is high. busy is high from the cycle after an accepted scan_start through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_start | input | 1 | Begin one pass over the frame |
| invalidate | input | 1 | Force the next pass to redraw everything |
| deep_mode | input | 1 | Include direct and control plane pages in the dirty test |
| active_lines | input | LINE_W | Number of active scan lines |
| active_width | input | COL_W | Active width reported in every rectangle |
| lk_req | output | 1 | Dirty lookup request |
| lk_band | output | LINE_W-2 | Band (page) index being looked up |
| lk_ack | input | 1 | Lookup answer valid |
| lk_base_dirty | input | 1 | Dirty flag of the band's base page |
| lk_direct_dirty | input | PLANE_PAGES | Dirty flags of the band's direct-colour pages |
| lk_ctrl_dirty | input | PLANE_PAGES | Dirty flags of the band's control pages |
| rect_valid | output | 1 | Update rectangle offered |
| rect_ready | input | 1 | Downstream accepts the rectangle |
| rect_y | output | LINE_W | First line of the rectangle |
| rect_h | output | LINE_W+1 | Height in lines |
| rect_w | output | COL_W | Width in pixels |
| clr_valid | output | 1 | Clear request for the dirty range |
| clr_lo | output | LINE_W-2 | Lowest dirty band |
| clr_hi | output | LINE_W-2 | Highest dirty band |
| done | output | 1 | Pass finished |
| busy | output | 1 | Pass in progress |

## Verification
The hardest situation to reach from the ports is a run that has to close while the previous rectangle is still held by a stalled consumer and the lookup store answers slowly. Only in that case do stall hold, lookup suppression and the band step all interact. The stimulus alternates dirty and clean bands, throttles rect_ready with a pseudo-random sequence, and delays every acknowledge by two cycles. A separate case uses the largest band count, with the first and last bands dirty, to exercise the index wrap at the end of the frame.

// File: rtl/dbc_pkg.sv
`timescale 1ns/1ps
package dbc_pkg;
  // log2 of the scan lines per band
  localparam int BAND_SHIFT = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_EMIT,
    S_FIN,
    S_DONE
  } dbc_state_t;
endpackage

// File: rtl/dbc_band_judge.sv
`timescale 1ns/1ps
module dbc_band_judge #(
  parameter int PLANE_PAGES = 4
) (
  input  logic                   force_all,
  input  logic                   deep,
  input  logic                   base_dirty,
  input  logic [PLANE_PAGES-1:0] direct_dirty,
  input  logic [PLANE_PAGES-1:0] ctrl_dirty,
  output logic                   hit
);
  logic [PLANE_PAGES-1:0] lane_hit;

  for (genvar i = 0; i < PLANE_PAGES; i++) begin : g_lane
    assign lane_hit[i] = direct_dirty[i] | ctrl_dirty[i];
  end

  assign hit = force_all | base_dirty | (deep & (|lane_hit));
endmodule

// File: rtl/dbc_range_track.sv
`timescale 1ns/1ps
module dbc_range_track #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] lo,
  output logic [IDX_W-1:0] hi,
  output logic             any
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '1;
      hi <= '0;
    end else if (init) begin
      lo <= '1;
      hi <= '0;
    end else if (upd) begin
      if (idx < lo) lo <= idx;
      if (idx > hi) hi <= idx;
    end
  end

  assign any = (lo <= hi);
endmodule

// File: rtl/dirty_band_coalescer.sv
`timescale 1ns/1ps
module dirty_band_coalescer import dbc_pkg::*; #(
  parameter int  LINE_W      = 10,
  parameter int  COL_W       = 11,
  parameter int  PLANE_PAGES = 4,
  localparam int BAND_W      = LINE_W - BAND_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scan_start,
  input  logic                   invalidate,
  input  logic                   deep_mode,
  input  logic [LINE_W-1:0]      active_lines,
  input  logic [COL_W-1:0]       active_width,
  output logic                   lk_req,
  output logic [BAND_W-1:0]      lk_band,
  input  logic                   lk_ack,
  input  logic                   lk_base_dirty,
  input  logic [PLANE_PAGES-1:0] lk_direct_dirty,
  input  logic [PLANE_PAGES-1:0] lk_ctrl_dirty,
  output logic                   rect_valid,
  input  logic                   rect_ready,
  output logic [LINE_W-1:0]      rect_y,
  output logic [LINE_W:0]        rect_h,
  output logic [COL_W-1:0]       rect_w,
  output logic                   clr_valid,
  output logic [BAND_W-1:0]      clr_lo,
  output logic [BAND_W-1:0]      clr_hi,
  output logic                   done,
  output logic                   busy
);
  // first scan line of a band index (one extra bit so the line past the last band fits)
  function automatic logic [LINE_W:0] band_line(input logic [BAND_W:0] b);
    return {b, {BAND_SHIFT{1'b0}}};
  endfunction

  dbc_state_t          st;
  logic [BAND_W-1:0]   band_q;
  logic                run_open;
  logic [LINE_W-1:0]   run_y;
  logic [LINE_W-1:0]   lines_q;
  logic [COL_W-1:0]    width_q;
  logic                full_q, deep_q, pend_q, last_q;
  logic [LINE_W-1:0]   ry_q;
  logic [LINE_W:0]     rh_q;

  logic                hit;
  logic [LINE_W:0]     cur_line, nxt_line;
  logic [LINE_W-1:0]   tail_y;
  logic                at_end;
  logic                start_acc;
  logic                ev_take, ev_close, ev_tail;
  logic                rng_any;

  dbc_band_judge #(.PLANE_PAGES(PLANE_PAGES)) u_judge (
    .force_all   (full_q),
    .deep        (deep_q),
    .base_dirty  (lk_base_dirty),
    .direct_dirty(lk_direct_dirty),
    .ctrl_dirty  (lk_ctrl_dirty),
    .hit         (hit)
  );

  assign start_acc = (st == S_IDLE) && scan_start;
  assign ev_take   = (st == S_LOOK) && lk_ack;
  assign cur_line  = band_line({1'b0, band_q});
  assign nxt_line  = band_line({1'b0, band_q} + (BAND_W+1)'(1));
  assign at_end    = nxt_line >= {1'b0, lines_q};
  assign tail_y    = run_open ? run_y : cur_line[LINE_W-1:0];
  assign ev_close  = ev_take && !hit && run_open;
  assign ev_tail   = ev_take && hit && at_end;

  dbc_range_track #(.IDX_W(BAND_W)) u_range (
    .clk  (clk),
    .rst_n(rst_n),
    .init (start_acc),
    .upd  (ev_take && hit),
    .idx  (band_q),
    .lo   (clr_lo),
    .hi   (clr_hi),
    .any  (rng_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      band_q   <= '0;
      run_open <= 1'b0;
      run_y    <= '0;
      lines_q  <= '0;
      width_q  <= '0;
      full_q   <= 1'b0;
      deep_q   <= 1'b0;
      pend_q   <= 1'b0;
      last_q   <= 1'b0;
      ry_q     <= '0;
      rh_q     <= '0;
    end else begin
      if (invalidate && !start_acc) pend_q <= 1'b1;
      case (st)
        S_IDLE: begin
          if (scan_start) begin
            band_q   <= '0;
            run_open <= 1'b0;
            lines_q  <= active_lines;
            width_q  <= active_width;
            deep_q   <= deep_mode;
            full_q   <= pend_q | invalidate;
            pend_q   <= 1'b0;
            st       <= (active_lines == '0) ? S_FIN : S_LOOK;
          end
        end
        S_LOOK: begin
          if (ev_take) begin
            band_q <= band_q + BAND_W'(1);
            if (ev_tail) begin
              ry_q     <= tail_y;
              rh_q     <= nxt_line - {1'b0, tail_y};
              run_open <= 1'b0;
              last_q   <= 1'b1;
              st       <= S_EMIT;
            end else if (hit) begin
              if (!run_open) run_y <= cur_line[LINE_W-1:0];
              run_open <= 1'b1;
            end else if (ev_close) begin
              ry_q     <= run_y;
              rh_q     <= cur_line - {1'b0, run_y};
              run_open <= 1'b0;
              last_q   <= at_end;
              st       <= S_EMIT;
            end else if (at_end) begin
              st <= S_FIN;
            end
          end
        end
        S_EMIT:  if (rect_ready) st <= last_q ? S_FIN : S_LOOK;
        S_FIN:   st <= rng_any ? S_DONE : S_IDLE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign lk_req     = (st == S_LOOK);
  assign lk_band    = band_q;
  assign rect_valid = (st == S_EMIT);
  assign rect_y     = ry_q;
  assign rect_h     = rh_q;
  assign rect_w     = width_q;
  assign clr_valid  = (st == S_FIN) && rng_any;
  assign done       = ((st == S_FIN) && !rng_any) || (st == S_DONE);
  assign busy       = (st != S_IDLE);
endmodule

// File: rtl/dirty_band_coalescer_chk.sv
`timescale 1ns/1ps
module dirty_band_coalescer_chk #(
  parameter int LINE_W = 10,
  parameter int COL_W  = 11,
  parameter int BAND_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic [BAND_W-1:0] lk_band,
  input logic              ev_take,
  input logic              ev_close,
  input logic              ev_tail,
  input logic              rect_valid,
  input logic              rect_ready,
  input logic [LINE_W-1:0] rect_y,
  input logic [LINE_W:0]   rect_h,
  input logic [COL_W-1:0]  rect_w,
  input logic              clr_valid,
  input logic [BAND_W-1:0] clr_lo,
  input logic [BAND_W-1:0] clr_hi,
  input logic              done,
  input logic              busy
);
  p_close_emits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> rect_valid && rect_h != '0 && rect_h[1:0] == 2'b00 && rect_y[1:0] == 2'b00);

  p_tail_emits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tail |=> rect_valid && rect_h != '0);

  p_band_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> lk_band == $past(lk_band) + BAND_W'(1));

  p_clear_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> clr_lo <= clr_hi);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid && !rect_ready |=> rect_valid && $stable(rect_y) && $stable(rect_h) && $stable(rect_w));

  p_no_lookup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> !lk_req);

  p_done_after_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> done && !clr_valid);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !lk_req && !rect_valid && !clr_valid && !done);
endmodule

bind dirty_band_coalescer dirty_band_coalescer_chk #(
  .LINE_W(LINE_W),
  .COL_W (COL_W),
  .BAND_W(BAND_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .lk_band   (lk_band),
  .ev_take   (ev_take),
  .ev_close  (ev_close),
  .ev_tail   (ev_tail),
  .rect_valid(rect_valid),
  .rect_ready(rect_ready),
  .rect_y    (rect_y),
  .rect_h    (rect_h),
  .rect_w    (rect_w),
  .clr_valid (clr_valid),
  .clr_lo    (clr_lo),
  .clr_hi    (clr_hi),
  .done      (done),
  .busy      (busy)
);

// File: tb/dirty_band_coalescer_test.sv
`timescale 1ns/1ps
module dirty_band_coalescer_test;
  localparam int LW = 10;
  localparam int CW = 11;
  localparam int BW = LW - 2;
  localparam int NB = 256;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          scan_start = 1'b0;
  logic          invalidate = 1'b0;
  logic          deep_mode = 1'b0;
  logic [LW-1:0] lines = '0;
  logic [CW-1:0] width = '0;
  logic          lk_req;
  logic [BW-1:0] lk_band;
  logic          lk_ack = 1'b0;
  logic          lk_base_dirty = 1'b0;
  logic [3:0]    lk_direct_dirty = '0;
  logic [3:0]    lk_ctrl_dirty = '0;
  logic          rect_valid;
  logic          rect_ready = 1'b0;
  logic [LW-1:0] rect_y;
  logic [LW:0]   rect_h;
  logic [CW-1:0] rect_w;
  logic          clr_valid;
  logic [BW-1:0] clr_lo, clr_hi;
  logic          done;
  logic          busy;

  dirty_band_coalescer #(.LINE_W(LW), .COL_W(CW), .PLANE_PAGES(4)) uut (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .invalidate(invalidate),
    .deep_mode(deep_mode), .active_lines(lines), .active_width(width),
    .lk_req(lk_req), .lk_band(lk_band), .lk_ack(lk_ack),
    .lk_base_dirty(lk_base_dirty), .lk_direct_dirty(lk_direct_dirty),
    .lk_ctrl_dirty(lk_ctrl_dirty), .rect_valid(rect_valid), .rect_ready(rect_ready),
    .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w), .clr_valid(clr_valid),
    .clr_lo(clr_lo), .clr_hi(clr_hi), .done(done), .busy(busy)
  );

  // dirty-bit store contents seen by the responder
  bit       base_d [NB];
  bit [3:0] dir_d  [NB];
  bit [3:0] ctl_d  [NB];

  // controls written by the stimulus only
  bit stall_mode = 1'b0;
  int ack_gap = 0;

  // observations written by the monitor only
  int obs_y[$], obs_h[$], obs_w[$], obs_band[$];
  int clr_cnt = 0, done_cnt = 0, stall_cnt = 0;
  int clr_lo_o = 0, clr_hi_o = 0, clr_cyc = 0, done_cyc = 0;
  int mon_total = 0, mon_bad = 0;

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock monitor and responder, working away from the active edge
  int  cyc_n = 0;
  int  gap_cnt = 0;
  bit  held = 1'b0;
  int  h_y = 0, h_h = 0, h_w = 0;
  logic [7:0] lfsr = 8'hA5;

  always @(negedge clk) begin
    cyc_n++;
    if (!rst_n) begin
      lk_ack = 1'b0;
      rect_ready = 1'b0;
      gap_cnt = 0;
      held = 1'b0;
    end else begin
      if (lk_req) begin
        if (gap_cnt >= ack_gap) begin
          lk_ack = 1'b1;
          lk_base_dirty = base_d[lk_band];
          lk_direct_dirty = dir_d[lk_band];
          lk_ctrl_dirty = ctl_d[lk_band];
          obs_band.push_back(int'(lk_band));
          gap_cnt = 0;
        end else begin
          lk_ack = 1'b0;
          gap_cnt++;
        end
      end else begin
        lk_ack = 1'b0;
        gap_cnt = 0;
      end

      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rect_ready = !stall_mode || (lfsr[0] && lfsr[2]);

      if (rect_valid) begin
        if (lk_req) begin
          mon_total++;
          mon_bad++;
          $display("FAIL R8 lookup during rectangle actual=%0d expected=%0d", 1, 0);
        end
        if (held) begin
          mon_total++;
          if (int'(rect_y) != h_y || int'(rect_h) != h_h || int'(rect_w) != h_w) begin
            mon_bad++;
            $display("FAIL R8 held rectangle changed actual=%0d expected=%0d", int'(rect_y), h_y);
          end
        end
        if (rect_ready) begin
          obs_y.push_back(int'(rect_y));
          obs_h.push_back(int'(rect_h));
          obs_w.push_back(int'(rect_w));
          held = 1'b0;
        end else begin
          held = 1'b1;
          stall_cnt++;
          h_y = int'(rect_y);
          h_h = int'(rect_h);
          h_w = int'(rect_w);
        end
      end else begin
        if (held) begin
          mon_total++;
          mon_bad++;
          $display("FAIL R8 rectangle withdrawn actual=%0d expected=%0d", 0, 1);
        end
        held = 1'b0;
      end

      if (clr_valid) begin
        clr_cnt++;
        clr_lo_o = int'(clr_lo);
        clr_hi_o = int'(clr_hi);
        clr_cyc = cyc_n;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc_n;
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", wd, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
      $finish;
    end
  end

  task automatic clear_store();
    for (int i = 0; i < NB; i++) begin
      base_d[i] = 1'b0;
      dir_d[i] = 4'h0;
      ctl_d[i] = 4'h0;
    end
  endtask

  task automatic pulse_invalidate();
    @(negedge clk) invalidate = 1'b1;
    @(negedge clk) invalidate = 1'b0;
  endtask

  // one pass: behavioural expectation, stimulus, then comparison
  task automatic run_scan(input int ln, input int wdt, input bit dp, input bit full,
                          input bit stall, input int gap, input bit restart, input bit inv_mid,
                          input string tag);
    int ey[$], eh[$];
    string et[$];
    int nb, st, lo, hi, ob, bb, c0, d0;
    bit open, dty;
    nb = (ln + 3) / 4;
    open = 0; st = 0; lo = 1 << 30; hi = -1;
    for (int b = 0; b < nb; b++) begin
      dty = full || base_d[b] || (dp && (dir_d[b] != 0 || ctl_d[b] != 0));
      if (dty) begin
        if (!open) begin open = 1; st = b * 4; end
        if (b < lo) lo = b;
        if (b > hi) hi = b;
      end else if (open) begin
        ey.push_back(st); eh.push_back(b * 4 - st); et.push_back("R2");
        open = 0;
      end
    end
    if (open) begin
      ey.push_back(st); eh.push_back(nb * 4 - st); et.push_back("R3");
    end

    ob = obs_y.size(); bb = obs_band.size(); c0 = clr_cnt; d0 = done_cnt;
    stall_mode = stall; ack_gap = gap;
    lines = LW'(ln); width = CW'(wdt); deep_mode = dp;
    @(negedge clk) scan_start = 1'b1;
    @(negedge clk) scan_start = 1'b0;
    if (restart || inv_mid) begin
      repeat (4) @(negedge clk);
      scan_start = restart;
      invalidate = inv_mid;
      @(negedge clk);
      scan_start = 1'b0;
      invalidate = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (12) @(negedge clk);

    chk(obs_y.size() - ob == ey.size(), "R2", {tag, " rectangle count"}, obs_y.size() - ob, ey.size());
    for (int i = 0; i < ey.size(); i++) begin
      if (ob + i < obs_y.size()) begin
        chk(obs_y[ob+i] == ey[i], et[i], {tag, " rect_y"}, obs_y[ob+i], ey[i]);
        chk(obs_h[ob+i] == eh[i], et[i], {tag, " rect_h"}, obs_h[ob+i], eh[i]);
        chk(obs_w[ob+i] == wdt, "R2", {tag, " rect_w"}, obs_w[ob+i], wdt);
      end
    end
    chk(obs_band.size() - bb == nb, "R4", {tag, " lookup count"}, obs_band.size() - bb, nb);
    begin
      int first_bad = -1;
      for (int i = 0; i < nb && bb + i < obs_band.size(); i++)
        if (obs_band[bb+i] != i && first_bad < 0) first_bad = i;
      chk(first_bad < 0, "R4", {tag, " lookup band order"},
          first_bad < 0 ? 0 : obs_band[bb+first_bad], first_bad < 0 ? 0 : first_bad);
    end
    chk(clr_cnt - c0 == (hi >= 0 ? 1 : 0), "R6", {tag, " clear count"}, clr_cnt - c0, hi >= 0 ? 1 : 0);
    if (hi >= 0) begin
      chk(clr_lo_o == lo, "R6", {tag, " clr_lo"}, clr_lo_o, lo);
      chk(clr_hi_o == hi, "R6", {tag, " clr_hi"}, clr_hi_o, hi);
      chk(done_cyc == clr_cyc + 1, "R9", {tag, " done after clear"}, done_cyc, clr_cyc + 1);
    end
    chk(done_cnt - d0 == 1, restart ? "R10" : "R9", {tag, " done pulses"}, done_cnt - d0, 1);
    chk(busy == 1'b0, "R10", {tag, " busy after done"}, int'(busy), 0);
  endtask

  initial begin
    int s0;
    clear_store();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lk_req == 1'b0, "R1", "lk_req after reset", int'(lk_req), 0);
    chk(rect_valid == 1'b0, "R1", "rect_valid after reset", int'(rect_valid), 0);
    chk(clr_valid == 1'b0, "R1", "clr_valid after reset", int'(clr_valid), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

    // R2/R3: two runs closed by clean bands, one open at the end
    clear_store();
    base_d[1] = 1; base_d[2] = 1; base_d[5] = 1; base_d[9] = 1;
    run_scan(40, 640, 0, 0, 0, 0, 0, 0, "runs");

    // R5: plane pages ignored in the shallow mode, counted in the deep mode
    clear_store();
    dir_d[3] = 4'b0100; ctl_d[4] = 4'b0001; base_d[7] = 1;
    run_scan(40, 320, 0, 0, 0, 1, 0, 0, "R5 shallow");
    run_scan(40, 320, 1, 0, 0, 1, 0, 0, "R5 deep");

    // R6: nothing dirty -> no rectangle, no clear
    clear_store();
    run_scan(40, 640, 1, 0, 0, 0, 0, 0, "R6 clean");

    // R8: alternating bands with a throttled consumer and slow lookups
    clear_store();
    for (int b = 0; b < 10; b += 2) base_d[b] = 1;
    s0 = stall_cnt;
    run_scan(40, 512, 0, 0, 1, 2, 0, 0, "R8 stall");
    chk(stall_cnt > s0, "R8", "stall cycles exercised", stall_cnt - s0, 1);

    // R3: height not a multiple of four, run reaches the end
    clear_store();
    base_d[0] = 1; base_d[1] = 1;
    run_scan(6, 100, 0, 0, 0, 0, 0, 0, "R3 short");

    // R7: invalidate forces one full pass only
    clear_store();
    pulse_invalidate();
    run_scan(40, 640, 0, 1, 0, 0, 0, 0, "R7 full");
    run_scan(40, 640, 0, 0, 0, 0, 0, 0, "R7 once");

    // R7: invalidate during a pass is deferred to the next pass
    base_d[4] = 1;
    run_scan(40, 640, 0, 0, 0, 1, 0, 1, "R7 mid");
    base_d[4] = 0;
    run_scan(40, 640, 0, 1, 0, 0, 0, 0, "R7 deferred");

    // R10: scan_start while busy is ignored
    clear_store();
    base_d[2] = 1;
    run_scan(40, 640, 0, 0, 0, 1, 1, 0, "R10 restart");

    // R3/R4: largest band count, first and last bands dirty
    clear_store();
    base_d[0] = 1; base_d[255] = 1;
    run_scan(1023, 1024, 0, 0, 0, 0, 0, 0, "R4 wide");

    $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  end
endmodule